// File: doc/BRIEF.md
# Read-Clear Interrupt Status Controller

This block collects single-cycle event pulses into a status register and drives an active-low interrupt request pin. A mask register chooses which status bits may pull the request low. Status bits record their events whatever the mask says. The lowest status bit is a power-on marker that is high for exactly one cycle after reset.

The block sits next to a serial register interface, which supplies strobes. One strobe marks the end of the command byte. One marks the end of the data byte. Two address-decode flags say whether the command targets the clearing status address or the plain status address. On a clearing read, a snapshot is taken at the end of the command byte and only the snapshotted bits are cleared, so an event that lands during the read is kept. The request pin is released from that point until the data byte completes. Then it re-asserts if anything enabled is still pending. On a plain read, a snapshot is taken and nothing else changes.

Top module: `irq_rdclr_ctrl`

## Requirements
- R1: An event pulse on `evt_i[k]` sets status bit k+1 at the next clock edge, whether or not mask bit k+1 is set.
- R2: Outside a clearing read, `irq_n` is low in the cycle after an edge exactly when the status register ANDed with the mask register is nonzero.
- R3: A cycle with `mask_we` high loads `mask_wdata` into the mask register, and `irq_n` follows the new mask from the next cycle.
- R4: When `cmd_done` and `rd_clr_hit` are high together, the status register is copied to `rd_data`, the copied bits are cleared, and `irq_n` is high in the following cycle.
- R5: After a clearing command, `irq_n` stays high in every cycle up to and including the edge at which `data_done` is seen.
- R6: After the `data_done` edge that ends a clearing read, `irq_n` goes low if any enabled status bit is pending, and stays high otherwise.
- R7: Status bit 0 reads 1 only for a read whose command completes at the first edge after reset is released, and reads 0 after that.
- R8: Events arriving in the command cycle of a clearing read, or later, remain set in the status register and are returned by the next read.
- R9: A read with `cmd_done` and `rd_plain_hit` high copies the status into `rd_data` without clearing any bit and without changing `irq_n`.
- R10: While `rst` is high and after it is released, the mask is 0 and the event bits are 0, so `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 7 | Event pulses for status bits 7..1 |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write data |
| cmd_done | input | 1 | Command byte finished strobe |
| rd_clr_hit | input | 1 | Command addresses the clearing status register |
| rd_plain_hit | input | 1 | Command addresses the non-clearing status register |
| data_done | input | 1 | Data byte finished strobe |
| rd_data | output | 8 | Status snapshot for the data byte |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A stuck or mis-set release flag shows up on `irq_n` in the first cycle after a clearing command or after `data_done`. A live register that clears too much or too little is only visible at the next read, so each clearing read is followed by a read that must return exactly the events injected during the previous transfer. Mask faults are visible on `irq_n` one cycle after the event or mask write. The reset marker bit is checked on the first read after reset and again on the read after it.

// File: rtl/irq_rdclr_ctrl.sv
module irq_rdclr_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-2:0] evt_i,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic         cmd_done,
  input  logic         rd_clr_hit,
  input  logic         rd_plain_hit,
  input  logic         data_done,
  output logic [W-1:0] rd_data,
  output logic         irq_n
);

  logic [W-1:1] live_q;
  logic         first_q;
  logic         hold_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] snap_q;
  logic [W-1:0] status;
  logic [W-1:0] clr_bits;
  logic         clr_cmd;
  logic         any_cmd;

  assign status   = {live_q, first_q};
  assign clr_cmd  = cmd_done & rd_clr_hit;
  assign any_cmd  = cmd_done & (rd_clr_hit | rd_plain_hit);
  assign clr_bits = clr_cmd ? status : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      first_q <= 1'b1;
      hold_q  <= 1'b0;
      mask_q  <= '0;
      snap_q  <= '0;
    end else begin
      first_q <= 1'b0;
      live_q  <= (live_q & ~clr_bits[W-1:1]) | evt_i;
      if (mask_we) mask_q <= mask_wdata;
      if (any_cmd) snap_q <= status;
      if (clr_cmd)        hold_q <= 1'b1;
      else if (data_done) hold_q <= 1'b0;
    end
  end

  assign rd_data = snap_q;
  assign irq_n   = hold_q | ~|(status & mask_q);

endmodule

module irq_rdclr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-2:0] evt_i,
  input logic         mask_we,
  input logic [W-1:0] mask_q,
  input logic         cmd_done,
  input logic         rd_clr_hit,
  input logic         rd_plain_hit,
  input logic         data_done,
  input logic         irq_n
);

  logic in_xfer;
  always_ff @(posedge clk) begin
    if (rst) in_xfer <= 1'b0;
    else if (cmd_done && rd_clr_hit) in_xfer <= 1'b1;
    else if (data_done) in_xfer <= 1'b0;
  end

  // R4
  clr_release_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && rd_clr_hit) |=> irq_n);

  // R5
  xfer_high_chk: assert property (@(posedge clk) disable iff (rst)
    in_xfer |-> irq_n);

  // R2
  enabled_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (((evt_i & mask_q[W-1:1]) != '0) && !mask_we && !in_xfer && !(cmd_done && rd_clr_hit))
      |=> !irq_n);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> irq_n);

  // R9
  plain_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && rd_plain_hit && !rd_clr_hit && !in_xfer && (evt_i == '0) && !mask_we && !data_done)
      |=> $stable(irq_n));

endmodule

bind irq_rdclr_ctrl irq_rdclr_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .mask_we(mask_we), .mask_q(mask_q),
  .cmd_done(cmd_done), .rd_clr_hit(rd_clr_hit), .rd_plain_hit(rd_plain_hit),
  .data_done(data_done), .irq_n(irq_n)
);

// File: tb/test_irq_rdclr_ctrl.sv
`timescale 1ns/1ps
module test_irq_rdclr_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] evt_i = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic       cmd_done = 1'b0;
  logic       rd_clr_hit = 1'b0;
  logic       rd_plain_hit = 1'b0;
  logic       data_done = 1'b0;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_st = '0;
  logic [7:0] exp_mask = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  irq_rdclr_ctrl i_irq_rdclr_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt_i), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .cmd_done(cmd_done), .rd_clr_hit(rd_clr_hit), .rd_plain_hit(rd_plain_hit),
    .data_done(data_done), .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return ~|(exp_st & exp_mask);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  // monitor: compares read data at each data byte completion
  always @(posedge clk) begin
    #1;
    if (!rst && data_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected data byte", rd_data, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end
  end

  task automatic pulse_evt(input logic [6:0] v, input string req);
    evt_i = v;
    exp_st |= {v, 1'b0};
    tick();
    evt_i = '0;
    check(irq_n === exp_irq(), req, {7'd0, irq_n}, {7'd0, exp_irq()});
  endtask

  task automatic write_mask(input logic [7:0] m);
    mask_we = 1'b1;
    mask_wdata = m;
    exp_mask = m;
    tick();
    mask_we = 1'b0;
    check(irq_n === exp_irq(), "R3 irq after mask write", {7'd0, irq_n}, {7'd0, exp_irq()});
  endtask

  task automatic do_read(input bit clr, input logic [6:0] e_cmd, input logic [6:0] e_mid,
                         input bit first, input string req);
    logic irq_before;
    irq_before = irq_n;
    cmd_done = 1'b1;
    rd_clr_hit = clr;
    rd_plain_hit = !clr;
    evt_i = e_cmd;
    exp_q.push_back(exp_st | {7'd0, first});
    tag_q.push_back(req);
    if (clr) exp_st = {e_cmd, 1'b0};
    else exp_st |= {e_cmd, 1'b0};
    tick();
    cmd_done = 1'b0;
    rd_clr_hit = 1'b0;
    rd_plain_hit = 1'b0;
    evt_i = '0;
    if (clr) check(irq_n === 1'b1, "R4 irq released after command", {7'd0, irq_n}, 8'h01);
    else if (e_cmd == '0)
      check(irq_n === irq_before, "R9 plain read leaves irq", {7'd0, irq_n}, {7'd0, irq_before});
    evt_i = e_mid;
    exp_st |= {e_mid, 1'b0};
    tick();
    evt_i = '0;
    if (clr) check(irq_n === 1'b1, "R5 irq held during data byte", {7'd0, irq_n}, 8'h01);
    data_done = 1'b1;
    tick();
    data_done = 1'b0;
    check(irq_n === exp_irq(), "R6 irq after data byte", {7'd0, irq_n}, {7'd0, exp_irq()});
  endtask

  initial begin
    repeat (3) tick();
    check(irq_n === 1'b1, "R10 irq during reset", {7'd0, irq_n}, 8'h01);
    rst = 1'b0;
    do_read(1'b0, 7'h00, 7'h00, 1'b1, "R7 marker on first read");
    do_read(1'b0, 7'h00, 7'h00, 1'b0, "R7 marker gone");
    check(irq_n === 1'b1, "R10 irq idle after reset", {7'd0, irq_n}, 8'h01);
    pulse_evt(7'h05, "R1 masked event keeps irq high");
    do_read(1'b0, 7'h00, 7'h00, 1'b0, "R1 masked event recorded");
    do_read(1'b0, 7'h00, 7'h00, 1'b0, "R9 plain read did not clear");
    write_mask(8'h02);
    do_read(1'b1, 7'h10, 7'h01, 1'b0, "R4 clearing read snapshot");
    do_read(1'b1, 7'h00, 7'h00, 1'b0, "R8 late events kept");
    check(irq_n === 1'b1, "R6 nothing pending", {7'd0, irq_n}, 8'h01);
    write_mask(8'hFF);
    pulse_evt(7'h40, "R2 enabled event asserts irq");
    pulse_evt(7'h01, "R2 second event keeps irq low");
    do_read(1'b1, 7'h00, 7'h00, 1'b0, "R4 clear two events");
    write_mask(8'h00);
    pulse_evt(7'h08, "R2 all masked");
    write_mask(8'h10);
    do_read(1'b0, 7'h00, 7'h00, 1'b0, "R9 plain read with pending");
    do_read(1'b1, 7'h00, 7'h00, 1'b0, "R4 final clear");
    check(exp_q.size() == 0, "R4 all reads observed", 8'(exp_q.size()), 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h01, 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule